// File: doc/BRIEF.md
# Multi-Connection Open/Close Sequencer

This controller sits on the user side of a TCP offload engine. On a start command it opens a batch of active connections to a single destination IP address. It issues one open request at a time. Connection `i` of the batch targets destination port `base + i`. Every session identifier that comes back with a success response is stored in a small on-chip table. Failed connections are counted and not retried.

On a later close command the controller walks the table in the order the sessions were stored. It sends one close request per stored identifier, and each close request carries only that identifier. Two counters report how many opens succeeded and how many failed. A done flag marks the end of each phase.

All traffic uses valid/ready channels: open request (IP address and port), open response (success flag and session identifier) and close request (session identifier). The TCP handshake itself and all data movement happen elsewhere.

Top module: `conn_seq_top`

## Requirements
- R1: After reset the following are all 0: `open_req_valid_o`, `close_req_valid_o`, `open_rsp_ready_o`, `busy_o`, `done_o`, `ok_cnt_o` and `fail_cnt_o`.
- R2: The k-th open request of a batch (k counted from 0) carries the IP address sampled at start and port `(base + k) mod 2^16`, with `base` sampled at start.
- R3: At most one open request is outstanding. `open_rsp_ready_o` is 1 only after a request has been accepted and before its response arrives. No new request is raised while a response is pending.
- R4: A response with `open_rsp_ok_i = 1` stores `open_rsp_sid_i` in the next free table entry and increments `ok_cnt_o`. A response with `open_rsp_ok_i = 0` increments `fail_cnt_o`. The port of a failed connection is never requested again.
- R5: The connection count is sampled at start and clamped to the range 1 to DEPTH: 0 becomes 1, and any value above DEPTH becomes DEPTH. Later changes to `n_conn_i`, `dst_ip_i` or `base_port_i` have no effect on the running batch.
- R6: `busy_o` is 1 while a phase runs. `done_o` goes to 1 in the cycle after the last response or the last close handshake of a phase, and stays at 1 until the next accepted command.
- R7: After a close command, exactly `ok_cnt_o` close requests follow, each carrying a stored identifier, in the order the identifiers were stored. After the last one, `done_o` is set. Open and close requests are never valid together.
- R8: A close command given when `ok_cnt_o` is 0 sets `done_o` in the next cycle and produces no close request.
- R9: A valid request keeps its valid signal and its payload unchanged until ready is seen.
- R10: If `start_i` and `close_i` are both 1 while the controller is idle, start wins. `start_i` and `close_i` are ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an open batch (idle only) |
| close_i | input | 1 | Begin closing stored sessions (idle only) |
| dst_ip_i | input | IP_W | Destination IP address, sampled at start |
| base_port_i | input | PORT_W | First destination port, sampled at start |
| n_conn_i | input | N_W | Requested connection count, sampled at start |
| open_req_valid_o | output | 1 | Open request valid |
| open_req_ready_i | input | 1 | Open request accepted |
| open_req_ip_o | output | IP_W | Open request destination IP |
| open_req_port_o | output | PORT_W | Open request destination port |
| open_rsp_valid_i | input | 1 | Open response valid |
| open_rsp_ready_o | output | 1 | Controller waits for a response |
| open_rsp_ok_i | input | 1 | 1 = connection established, 0 = failed |
| open_rsp_sid_i | input | SID_W | Session identifier of a successful open |
| close_req_valid_o | output | 1 | Close request valid |
| close_req_ready_i | input | 1 | Close request accepted |
| close_req_sid_o | output | SID_W | Session identifier to close |
| busy_o | output | 1 | A phase is running |
| done_o | output | 1 | Last phase finished |
| ok_cnt_o | output | CNT_W | Successful opens of the last batch |
| fail_cnt_o | output | CNT_W | Failed opens of the last batch |

## Verification
The hardest situations to reach are those where the controller must hold its state across several interleaved stalls. One is a response that arrives several cycles after the request handshake while a stray command and changed batch inputs are applied. The other is a close walk over a table that holds only some of the responses, so that identifiers and order must still line up. The bench drives long randomized batches with random ready and response delays and a random success pattern. After each start it overwrites the sampled inputs with garbage and pulses `close_i` while a response is pending. Directed runs add a count of zero, a count above the table depth, a port range that wraps past 65535, an all-failure batch followed by a close, and a start and close given in the same cycle.

// File: rtl/conn_seq_pkg.sv
package conn_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OREQ  = 3'd1,
    ST_ORSP  = 3'd2,
    ST_CRD   = 3'd3,
    ST_CSEND = 3'd4
  } seq_state_e;
endpackage

// File: rtl/conn_count_clamp.sv
module conn_count_clamp #(
  parameter int N_W   = 8,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [N_W-1:0]   n_raw_i,
  output logic [CNT_W-1:0] n_eff_o
);
  localparam int EXT_W = (N_W > CNT_W) ? N_W + 1 : CNT_W + 1;
  logic [EXT_W-1:0] n_ext;

  always_comb begin
    n_ext = EXT_W'(n_raw_i);
    if (n_ext == '0)
      n_eff_o = CNT_W'(1);
    else if (n_ext > EXT_W'(DEPTH))
      n_eff_o = CNT_W'(DEPTH);
    else
      n_eff_o = CNT_W'(n_ext);
  end
endmodule

// File: rtl/sid_store.sv
module sid_store #(
  parameter int SID_W = 16,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [SID_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [SID_W-1:0] rd_data_o
);
  logic [SID_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i)
      mem[wr_addr_i] <= wr_data_i;
    rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/conn_seq_top.sv
module conn_seq_top
  import conn_seq_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int PORT_W = 16,
  parameter int SID_W  = 16,
  parameter int N_W    = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              close_i,
  input  logic [IP_W-1:0]   dst_ip_i,
  input  logic [PORT_W-1:0] base_port_i,
  input  logic [N_W-1:0]    n_conn_i,
  output logic              open_req_valid_o,
  input  logic              open_req_ready_i,
  output logic [IP_W-1:0]   open_req_ip_o,
  output logic [PORT_W-1:0] open_req_port_o,
  input  logic              open_rsp_valid_i,
  output logic              open_rsp_ready_o,
  input  logic              open_rsp_ok_i,
  input  logic [SID_W-1:0]  open_rsp_sid_i,
  output logic              close_req_valid_o,
  input  logic              close_req_ready_i,
  output logic [SID_W-1:0]  close_req_sid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  ok_cnt_o,
  output logic [CNT_W-1:0]  fail_cnt_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  seq_state_e       state_q;
  logic [CNT_W-1:0] n_q, idx_q, cidx_q, ok_q, fail_q, n_eff;
  logic             done_q, oreq_v_q, creq_v_q;
  logic [PORT_W-1:0] port_q;
  logic [IP_W-1:0]   ip_q;
  logic             rsp_take, wr_en;

  conn_count_clamp #(.N_W(N_W), .DEPTH(DEPTH)) u_clamp (
    .n_raw_i (n_conn_i),
    .n_eff_o (n_eff)
  );

  assign rsp_take = (state_q == ST_ORSP) && open_rsp_valid_i;
  assign wr_en    = rsp_take && open_rsp_ok_i;

  sid_store #(.SID_W(SID_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (ok_q[IDX_W-1:0]),
    .wr_data_i (open_rsp_sid_i),
    .rd_addr_i (cidx_q[IDX_W-1:0]),
    .rd_data_o (close_req_sid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      n_q      <= CNT_W'(1);
      idx_q    <= '0;
      cidx_q   <= '0;
      ok_q     <= '0;
      fail_q   <= '0;
      done_q   <= 1'b0;
      oreq_v_q <= 1'b0;
      creq_v_q <= 1'b0;
      port_q   <= '0;
      ip_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            n_q      <= n_eff;
            idx_q    <= '0;
            ok_q     <= '0;
            fail_q   <= '0;
            done_q   <= 1'b0;
            port_q   <= base_port_i;
            ip_q     <= dst_ip_i;
            oreq_v_q <= 1'b1;
            state_q  <= ST_OREQ;
          end else if (close_i) begin
            cidx_q <= '0;
            if (ok_q == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q  <= 1'b0;
              state_q <= ST_CRD;
            end
          end
        end
        ST_OREQ: begin
          if (open_req_ready_i) begin
            oreq_v_q <= 1'b0;
            state_q  <= ST_ORSP;
          end
        end
        ST_ORSP: begin
          if (open_rsp_valid_i) begin
            if (open_rsp_ok_i) ok_q <= ok_q + CNT_W'(1);
            else               fail_q <= fail_q + CNT_W'(1);
            if (idx_q == n_q - CNT_W'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q    <= idx_q + CNT_W'(1);
              port_q   <= port_q + PORT_W'(1);
              oreq_v_q <= 1'b1;
              state_q  <= ST_OREQ;
            end
          end
        end
        ST_CRD: begin
          creq_v_q <= 1'b1;
          state_q  <= ST_CSEND;
        end
        ST_CSEND: begin
          if (close_req_ready_i) begin
            creq_v_q <= 1'b0;
            if (cidx_q == ok_q - CNT_W'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cidx_q  <= cidx_q + CNT_W'(1);
              state_q <= ST_CRD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign open_req_valid_o  = oreq_v_q;
  assign open_req_ip_o     = ip_q;
  assign open_req_port_o   = port_q;
  assign open_rsp_ready_o  = (state_q == ST_ORSP);
  assign close_req_valid_o = creq_v_q;
  assign busy_o            = (state_q != ST_IDLE);
  assign done_o            = done_q;
  assign ok_cnt_o          = ok_q;
  assign fail_cnt_o        = fail_q;

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    open_req_valid_o |-> !open_rsp_ready_o); // R3

  AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    open_req_valid_o && !open_req_ready_i |=>
      open_req_valid_o && $stable(open_req_port_o) && $stable(open_req_ip_o)); // R9

  AST_CLOSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    close_req_valid_o && !close_req_ready_i |=>
      close_req_valid_o && $stable(close_req_sid_o)); // R9

  AST_PORT_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(open_req_valid_o) && $past(state_q) == ST_ORSP |->
      open_req_port_o == $past(open_req_port_o) + PORT_W'(1)); // R2

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (CNT_W + 1)'(ok_q) + (CNT_W + 1)'(fail_q) <= (CNT_W + 1)'(n_q)
      && n_q >= CNT_W'(1) && n_q <= CNT_W'(DEPTH)); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R6

  AST_NO_MIX: assert property (@(posedge clk) disable iff (rst)
    !(open_req_valid_o && close_req_valid_o)); // R7
endmodule

// File: tb/test_conn_seq_top.sv
module test_conn_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, close_i = 0;
  logic [31:0] dst_ip_i = '0;
  logic [15:0] base_port_i = '0;
  logic [7:0]  n_conn_i = '0;
  logic open_req_valid_o, open_req_ready_i = 0;
  logic [31:0] open_req_ip_o;
  logic [15:0] open_req_port_o;
  logic open_rsp_valid_i = 0, open_rsp_ready_o, open_rsp_ok_i = 0;
  logic [15:0] open_rsp_sid_i = '0;
  logic close_req_valid_o, close_req_ready_i = 0;
  logic [15:0] close_req_sid_o;
  logic busy_o, done_o;
  logic [CNT_W-1:0] ok_cnt_o, fail_cnt_o;

  int compared = 0;
  int mismatched = 0;
  int exp_ok = 0;
  int exp_fail = 0;
  logic [15:0] exp_sid [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  conn_seq_top #(.DEPTH(DEPTH)) i_conn_seq_top (
    .clk, .rst, .start_i, .close_i, .dst_ip_i, .base_port_i, .n_conn_i,
    .open_req_valid_o, .open_req_ready_i, .open_req_ip_o, .open_req_port_o,
    .open_rsp_valid_i, .open_rsp_ready_o, .open_rsp_ok_i, .open_rsp_sid_i,
    .close_req_valid_o, .close_req_ready_i, .close_req_sid_o,
    .busy_o, .done_o, .ok_cnt_o, .fail_cnt_o
  );

  function automatic int clamp_n(input int n);
    if (n == 0) return 1;
    if (n > DEPTH) return DEPTH;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic open_run(input logic [31:0] ip, input logic [15:0] base,
                          input logic [7:0] nraw, input int mode, input bit with_close);
    int n;
    n = clamp_n(int'(nraw));
    exp_ok = 0;
    exp_fail = 0;
    @(negedge clk);
    dst_ip_i = ip; base_port_i = base; n_conn_i = nraw;
    start_i = 1; close_i = with_close;
    @(negedge clk);
    start_i = 0; close_i = 0;
    dst_ip_i = $urandom; base_port_i = 16'($urandom); n_conn_i = 8'($urandom);
    chk(busy_o == 1, "R6 busy after start", longint'(busy_o), 1);
    if (with_close) chk(close_req_valid_o == 0 && open_req_valid_o == 1,
                        "R10 start wins", longint'(close_req_valid_o), 0);
    for (int k = 0; k < n; k++) begin
      logic [15:0] port_seen;
      int guard;
      bit ok_b;
      logic [15:0] sid;
      guard = 0;
      while (!open_req_valid_o && guard < 20) begin @(negedge clk); guard++; end
      chk(open_req_valid_o == 1, "R3 request raised", longint'(open_req_valid_o), 1);
      chk(open_req_ip_o == ip, "R2 ip", longint'(open_req_ip_o), longint'(ip));
      chk(open_req_port_o == 16'(base + 16'(k)), "R2 port", longint'(open_req_port_o),
          longint'(16'(base + 16'(k))));
      port_seen = open_req_port_o;
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(open_req_valid_o == 1 && open_req_port_o == port_seen, "R9 hold open",
            longint'(open_req_port_o), longint'(port_seen));
      end
      open_req_ready_i = 1;
      @(negedge clk);
      open_req_ready_i = 0;
      chk(open_rsp_ready_o == 1 && open_req_valid_o == 0, "R3 waiting for response",
          longint'({open_rsp_ready_o, open_req_valid_o}), 2);
      close_i = 1;
      @(negedge clk);
      close_i = 0;
      chk(open_req_valid_o == 0 && close_req_valid_o == 0, "R10 close ignored while busy",
          longint'({open_req_valid_o, close_req_valid_o}), 0);
      repeat ($urandom % 4) begin
        @(negedge clk);
        chk(open_req_valid_o == 0, "R3 no second request", longint'(open_req_valid_o), 0);
      end
      case (mode)
        0: ok_b = 1;
        1: ok_b = 0;
        default: ok_b = ($urandom % 3) != 0;
      endcase
      sid = 16'($urandom);
      open_rsp_valid_i = 1; open_rsp_ok_i = ok_b; open_rsp_sid_i = sid;
      if (ok_b) begin exp_sid[exp_ok] = sid; exp_ok++; end
      else exp_fail++;
      @(negedge clk);
      open_rsp_valid_i = 0; open_rsp_ok_i = 0;
    end
    chk(done_o == 1 && busy_o == 0, "R6 done after batch", longint'({done_o, busy_o}), 2);
    chk(int'(ok_cnt_o) == exp_ok, "R4 ok count", longint'(ok_cnt_o), longint'(exp_ok));
    chk(int'(fail_cnt_o) == exp_fail, "R4 fail count", longint'(fail_cnt_o), longint'(exp_fail));
    chk(open_req_valid_o == 0, "R5 no extra request beyond clamp", longint'(open_req_valid_o), 0);
    repeat (2) @(negedge clk);
    chk(open_req_valid_o == 0 && done_o == 1, "R4 R6 no retry, done held",
        longint'({open_req_valid_o, done_o}), 1);
  endtask

  task automatic close_run;
    @(negedge clk);
    close_i = 1;
    @(negedge clk);
    close_i = 0;
    if (exp_ok == 0) begin
      chk(done_o == 1 && busy_o == 0, "R8 immediate done", longint'({done_o, busy_o}), 2);
      chk(close_req_valid_o == 0, "R8 no close request", longint'(close_req_valid_o), 0);
      @(negedge clk);
      chk(close_req_valid_o == 0, "R8 still no close", longint'(close_req_valid_o), 0);
    end else begin
      chk(done_o == 0, "R6 done cleared by close", longint'(done_o), 0);
      for (int k = 0; k < exp_ok; k++) begin
        int guard;
        guard = 0;
        while (!close_req_valid_o && guard < 10) begin @(negedge clk); guard++; end
        chk(close_req_valid_o == 1 && open_req_valid_o == 0, "R7 close raised",
            longint'({close_req_valid_o, open_req_valid_o}), 2);
        chk(close_req_sid_o == exp_sid[k], "R7 sid order", longint'(close_req_sid_o),
            longint'(exp_sid[k]));
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(close_req_valid_o == 1 && close_req_sid_o == exp_sid[k], "R9 hold close",
              longint'(close_req_sid_o), longint'(exp_sid[k]));
        end
        close_req_ready_i = 1;
        @(negedge clk);
        close_req_ready_i = 0;
        chk(close_req_valid_o == 0, "R7 valid drops after handshake", longint'(close_req_valid_o), 0);
      end
      chk(done_o == 1 && busy_o == 0, "R7 done after close walk", longint'({done_o, busy_o}), 2);
      @(negedge clk);
      chk(close_req_valid_o == 0, "R7 no extra close", longint'(close_req_valid_o), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(open_req_valid_o == 0 && close_req_valid_o == 0 && open_rsp_ready_o == 0,
        "R1 valids in reset", longint'({open_req_valid_o, close_req_valid_o, open_rsp_ready_o}), 0);
    rst = 0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1 flags after reset", longint'({busy_o, done_o}), 0);
    chk(ok_cnt_o == 0 && fail_cnt_o == 0, "R1 counts after reset",
        longint'({ok_cnt_o, fail_cnt_o}), 0);

    open_run(32'h0A01_D479, 16'd5001, 8'd3, 0, 0);   // R2 R4 basic
    close_run();                                      // R7
    open_run(32'hC0A8_0001, 16'd80, 8'd0, 0, 0);      // R5 zero clamps to one
    open_run(32'h0102_0304, 16'd1000, 8'd200, 2, 0);  // R5 above depth
    close_run();
    open_run(32'h7F00_0001, 16'hFFFE, 8'd4, 0, 0);    // R2 wrap
    open_run(32'h0B0B_0B0B, 16'd7000, 8'd3, 1, 0);    // R4 all fail
    close_run();                                      // R8
    open_run(32'h0A00_0002, 16'd9000, 8'd2, 0, 0);
    open_run(32'h0A00_0003, 16'd9100, 8'd5, 2, 1);    // R10 start and close together
    close_run();
    for (int r = 0; r < 8; r++) begin
      open_run($urandom, 16'($urandom), 8'($urandom % 13), 2, 0);
      close_run();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule